// File: doc/BRIEF.md
# Zero-Suppressed Acquisition Sequencer

This block runs one acquisition cycle for a set of peak-hold channels that share a single converter. It watches a gate input, accepts a new event on the gate's rising edge, and on the falling edge raises busy and starts a programmable wait. After the wait, a first scan pass requests a sample from each enabled channel in turn. It keeps every channel whose upper eight sample bits lie strictly between a low and a high threshold, and it counts those channels.

If at least one channel is kept, a second pass converts each kept channel again through the same request/done handshake. The block writes a packet to the output FIFO: one header word, then one data word per kept channel in ascending channel order. When no channel is kept, nothing is written. In every completed event the 12-bit event counter advances by one and busy is released.

A pulse on the clear input has two meanings, chosen by a mode pin. In fast-clear mode, a pulse during the post-gate wait cancels the event. In reset mode, a pulse clears the counter, stops any sequence, and raises a clear strobe. The neighbouring register file and FIFO use that strobe to empty the buffer and restore their defaults. Busy also stays high while the FIFO cannot take more data. Which FIFO flag counts for this depends on the buffer mode.

Top module: `zs_acq_sequencer`

## Requirements
- R1: A rising gate edge starts an event only when `busy_o` is low and `chan_en_i` has at least one bit set; otherwise the block stays idle, makes no sample request and leaves the counter unchanged.
- R2: `busy_o` is high from the cycle after the gate's falling edge is seen until the sequence returns to idle, and it is also high whenever the FIFO blocks: `fifo_half_i` when `buf_full_mode_i`=0, `fifo_full_i` when `buf_full_mode_i`=1. No FIFO write happens while busy is low.
- R3: The first sample request rises exactly `delay_code_i`*STEP+OFFSET+2 cycles after `busy_o` rises (STEP=4, OFFSET=3 by default).
- R4: A channel is in range when its sample bits [11:4] are strictly greater than `thr_lo_i` and strictly less than `thr_hi_i`; values equal to either threshold are out of range.
- R5: The header word has bit 15 = 1, bits [14:12] = (number of in-range channels - 1) and bits [11:0] = the event counter value before this event's increment, and it is the first word of the packet.
- R6: Each data word has bit 15 = 0, bits [14:12] = channel number and bits [11:0] = the converted value; there is one per in-range channel, in ascending channel order, after the header.
- R7: An event with no in-range channel writes no word; every completed event increments `evt_cnt_o` by one (modulo 4096), and the counter otherwise changes only by clearing to zero.
- R8: With `fast_clr_mode_i`=1, a `clr_i` pulse while the post-gate wait is running cancels the event: the block returns to idle, makes no sample request, writes nothing and leaves the counter unchanged.
- R9: With `fast_clr_mode_i`=1, a `clr_i` pulse outside the wait has no effect: no clear strobe, and an event in progress completes with its normal packet and count.
- R10: With `fast_clr_mode_i`=0, a `clr_i` pulse raises `cfg_clear_o` in the same cycle, sets the counter to zero and returns the block to idle on the next clock edge.
- R11: `smp_req_o` stays high with a stable `smp_ch_o` until `smp_done_i`; the first pass requests each enabled channel once in ascending order, and the second pass requests each in-range channel once more, so a completed event makes (enabled + in-range) requests.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gate_i | input | 1 | Gate level, synchronous to clk |
| clr_i | input | 1 | Clear / fast-clear pulse |
| fast_clr_mode_i | input | 1 | 1: clr_i aborts during the wait; 0: clr_i resets |
| buf_full_mode_i | input | 1 | 1: block on FIFO full; 0: block on FIFO half full |
| chan_en_i | input | 8 | Per-channel enable |
| thr_lo_i | input | 8 | Low threshold |
| thr_hi_i | input | 8 | High threshold |
| delay_code_i | input | 2 | Post-gate wait code |
| fifo_half_i | input | 1 | FIFO over half full |
| fifo_full_i | input | 1 | FIFO full |
| smp_done_i | input | 1 | Sample/conversion done strobe |
| smp_val_i | input | 12 | Sample/conversion value, valid with done |
| smp_req_o | output | 1 | Sample/conversion request |
| smp_ch_o | output | 3 | Channel being requested |
| fifo_wr_o | output | 1 | FIFO write strobe |
| fifo_wdata_o | output | 16 | FIFO write word |
| busy_o | output | 1 | Busy flag |
| evt_cnt_o | output | 12 | Event counter |
| cfg_clear_o | output | 1 | Clear strobe to FIFO and configuration |

## Verification
On every cycle, the in-module properties check four things: that an event starts only from an idle, unblocked state with some channel enabled, that writes happen only under busy, that a request holds its channel until done, and that the counter moves only by one step or to zero. They also cover the abort and reset-mode transitions. Other behaviour needs the bench's scenarios: the exact wait length for each delay code, the threshold edges at equality, packet contents and their ordering, and the number of handshakes per event. These are checked against a model in the bench over directed boundary cases and a pseudo-random sweep of enables, thresholds and samples.

// File: rtl/zs_acq_pkg.sv
package zs_acq_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_GATE,
        S_DELAY,
        S_SCAN_PICK,
        S_SCAN_WAIT,
        S_HDR,
        S_CONV_PICK,
        S_CONV_WAIT
    } seq_state_e;
endpackage

// File: rtl/zs_delay_timer.sv
module zs_delay_timer #(
    parameter int CODE_W = 2,
    parameter int STEP   = 4,
    parameter int OFS    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              expired_o
);
    localparam int MAXV  = ((1 << CODE_W) - 1) * STEP + OFS;
    localparam int CNT_W = $clog2(MAXV + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = CNT_W'(32'(code_i) * STEP + OFS);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q == '0);

    // R3
    countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
endmodule

// File: rtl/zs_window_cmp.sv
module zs_window_cmp #(
    parameter int THR_W = 8
) (
    input  logic [THR_W-1:0] top_i,
    input  logic [THR_W-1:0] lo_i,
    input  logic [THR_W-1:0] hi_i,
    output logic             inside_o
);
    assign inside_o = (top_i > lo_i) && (top_i < hi_i);
endmodule

// File: rtl/zs_next_chan.sv
module zs_next_chan #(
    parameter int NCH   = 8,
    parameter int CH_W  = 3,
    parameter int IDX_W = 4
) (
    input  logic [NCH-1:0]   mask_i,
    input  logic [IDX_W-1:0] from_i,
    output logic             found_o,
    output logic [CH_W-1:0]  chan_o
);
    always_comb begin
        found_o = 1'b0;
        chan_o  = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (mask_i[i] && (IDX_W'(i) >= from_i)) begin
                found_o = 1'b1;
                chan_o  = CH_W'(i);
            end
        end
    end
endmodule

// File: rtl/zs_acq_sequencer.sv
module zs_acq_sequencer
    import zs_acq_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int DW     = 12,
    parameter int THR_W  = 8,
    parameter int CODE_W = 2,
    parameter int STEP   = 4,
    parameter int OFS    = 3,
    localparam int CH_W   = $clog2(NCH),
    localparam int IDX_W  = $clog2(NCH + 1),
    localparam int WORD_W = 1 + CH_W + DW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gate_i,
    input  logic              clr_i,
    input  logic              fast_clr_mode_i,
    input  logic              buf_full_mode_i,
    input  logic [NCH-1:0]    chan_en_i,
    input  logic [THR_W-1:0]  thr_lo_i,
    input  logic [THR_W-1:0]  thr_hi_i,
    input  logic [CODE_W-1:0] delay_code_i,
    input  logic              fifo_half_i,
    input  logic              fifo_full_i,
    input  logic              smp_done_i,
    input  logic [DW-1:0]     smp_val_i,
    output logic              smp_req_o,
    output logic [CH_W-1:0]   smp_ch_o,
    output logic              fifo_wr_o,
    output logic [WORD_W-1:0] fifo_wdata_o,
    output logic              busy_o,
    output logic [DW-1:0]     evt_cnt_o,
    output logic              cfg_clear_o
);
    typedef struct packed {
        seq_state_e        st;
        logic              gate;
        logic [NCH-1:0]    en;
        logic [NCH-1:0]    hit;
        logic [IDX_W-1:0]  idx;
        logic [CH_W-1:0]   ch;
        logic [IDX_W-1:0]  mult;
        logic [DW-1:0]     evt;
        logic              wr;
        logic [WORD_W-1:0] wdata;
    } seq_t;

    seq_t d, q;

    logic             gate_rise, gate_fall, fifo_block, seq_busy;
    logic             tmr_load, tmr_expired;
    logic             pick_found, in_window, conv_pass;
    logic [CH_W-1:0]  pick_ch;
    logic [NCH-1:0]   pick_mask;
    logic [IDX_W-1:0] mult_m1;

    assign gate_rise  = gate_i & ~q.gate;
    assign gate_fall  = ~gate_i & q.gate;
    assign fifo_block = buf_full_mode_i ? fifo_full_i : fifo_half_i;
    assign seq_busy   = (q.st != S_IDLE) && (q.st != S_GATE);
    assign tmr_load   = (q.st == S_GATE) && gate_fall;
    assign conv_pass  = (q.st == S_CONV_PICK) || (q.st == S_CONV_WAIT);
    assign pick_mask  = conv_pass ? q.hit : q.en;
    assign mult_m1    = q.mult - IDX_W'(1);

    zs_delay_timer #(.CODE_W(CODE_W), .STEP(STEP), .OFS(OFS)) i_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load),
        .code_i    (delay_code_i),
        .expired_o (tmr_expired)
    );

    zs_window_cmp #(.THR_W(THR_W)) i_window (
        .top_i    (smp_val_i[DW-1 -: THR_W]),
        .lo_i     (thr_lo_i),
        .hi_i     (thr_hi_i),
        .inside_o (in_window)
    );

    zs_next_chan #(.NCH(NCH), .CH_W(CH_W), .IDX_W(IDX_W)) i_pick (
        .mask_i  (pick_mask),
        .from_i  (q.idx),
        .found_o (pick_found),
        .chan_o  (pick_ch)
    );

    always_comb begin
        d      = q;
        d.wr   = 1'b0;
        d.gate = gate_i;
        unique case (q.st)
            S_IDLE: begin
                if (gate_rise && !fifo_block && (|chan_en_i)) begin
                    d.st = S_GATE;
                    d.en = chan_en_i;
                end
            end
            S_GATE: begin
                if (gate_fall) d.st = S_DELAY;
            end
            S_DELAY: begin
                if (clr_i && fast_clr_mode_i) begin
                    d.st = S_IDLE;
                end else if (tmr_expired) begin
                    d.st   = S_SCAN_PICK;
                    d.idx  = '0;
                    d.mult = '0;
                    d.hit  = '0;
                end
            end
            S_SCAN_PICK: begin
                if (pick_found) begin
                    d.ch = pick_ch;
                    d.st = S_SCAN_WAIT;
                end else if (q.mult == '0) begin
                    d.evt = q.evt + DW'(1);
                    d.st  = S_IDLE;
                end else begin
                    d.st = S_HDR;
                end
            end
            S_SCAN_WAIT: begin
                if (smp_done_i) begin
                    if (in_window) begin
                        d.hit[q.ch] = 1'b1;
                        d.mult      = q.mult + IDX_W'(1);
                    end
                    d.idx = IDX_W'(q.ch) + IDX_W'(1);
                    d.st  = S_SCAN_PICK;
                end
            end
            S_HDR: begin
                d.wr    = 1'b1;
                d.wdata = {1'b1, mult_m1[CH_W-1:0], q.evt};
                d.idx   = '0;
                d.st    = S_CONV_PICK;
            end
            S_CONV_PICK: begin
                if (pick_found) begin
                    d.ch = pick_ch;
                    d.st = S_CONV_WAIT;
                end else begin
                    d.evt = q.evt + DW'(1);
                    d.st  = S_IDLE;
                end
            end
            S_CONV_WAIT: begin
                if (smp_done_i) begin
                    d.wr    = 1'b1;
                    d.wdata = {1'b0, q.ch, smp_val_i};
                    d.idx   = IDX_W'(q.ch) + IDX_W'(1);
                    d.st    = S_CONV_PICK;
                end
            end
            default: d.st = S_IDLE;
        endcase
        if (clr_i && !fast_clr_mode_i) begin
            d.st  = S_IDLE;
            d.evt = '0;
            d.wr  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: S_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign smp_req_o    = (q.st == S_SCAN_WAIT) || (q.st == S_CONV_WAIT);
    assign smp_ch_o     = q.ch;
    assign fifo_wr_o    = q.wr;
    assign fifo_wdata_o = q.wdata;
    assign busy_o       = seq_busy || fifo_block;
    assign evt_cnt_o    = q.evt;
    assign cfg_clear_o  = clr_i && !fast_clr_mode_i;

    // R1
    gate_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_GATE && $past(q.st) == S_IDLE)
            |-> $past(!busy_o && (|chan_en_i) && gate_i));

    // R2
    write_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr_o |-> busy_o);

    // R7
    evt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(evt_cnt_o) |-> (evt_cnt_o == $past(evt_cnt_o) + DW'(1) || evt_cnt_o == '0));

    // R8
    abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_DELAY && clr_i && fast_clr_mode_i)
            |=> (q.st == S_IDLE && $stable(evt_cnt_o) && !fifo_wr_o));

    // R10
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !fast_clr_mode_i) |=> (evt_cnt_o == '0 && q.st == S_IDLE));

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_req_o && !smp_done_i && !(clr_i && !fast_clr_mode_i))
            |=> (smp_req_o && $stable(smp_ch_o)));
endmodule

// File: tb/test_zs_acq_sequencer.sv
module test_zs_acq_sequencer;
    localparam int STEP = 4;
    localparam int OFS  = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        gate_i = 1'b0;
    logic        clr_i = 1'b0;
    logic        fast_clr_mode_i = 1'b1;
    logic        buf_full_mode_i = 1'b0;
    logic [7:0]  chan_en_i = '0;
    logic [7:0]  thr_lo_i = '0;
    logic [7:0]  thr_hi_i = '0;
    logic [1:0]  delay_code_i = '0;
    logic        fifo_half_i = 1'b0;
    logic        fifo_full_i = 1'b0;
    logic        smp_done_i = 1'b0;
    logic [11:0] smp_val_i = '0;
    logic        smp_req_o;
    logic [2:0]  smp_ch_o;
    logic        fifo_wr_o;
    logic [15:0] fifo_wdata_o;
    logic        busy_o;
    logic [11:0] evt_cnt_o;
    logic        cfg_clear_o;

    int checks = 0;
    int fails  = 0;
    int exp_evt = 0;
    int req_n = 0;
    int cap_n = 0;
    logic [15:0] cap [16];
    logic [11:0] samp [8];
    logic [31:0] seed = 32'h1234_5677;

    always #4 clk = ~clk;

    zs_acq_sequencer i_zs_acq_sequencer (
        .clk(clk), .rst_n(rst_n), .gate_i(gate_i), .clr_i(clr_i),
        .fast_clr_mode_i(fast_clr_mode_i), .buf_full_mode_i(buf_full_mode_i),
        .chan_en_i(chan_en_i), .thr_lo_i(thr_lo_i), .thr_hi_i(thr_hi_i),
        .delay_code_i(delay_code_i), .fifo_half_i(fifo_half_i), .fifo_full_i(fifo_full_i),
        .smp_done_i(smp_done_i), .smp_val_i(smp_val_i), .smp_req_o(smp_req_o),
        .smp_ch_o(smp_ch_o), .fifo_wr_o(fifo_wr_o), .fifo_wdata_o(fifo_wdata_o),
        .busy_o(busy_o), .evt_cnt_o(evt_cnt_o), .cfg_clear_o(cfg_clear_o)
    );

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // sample/convert responder, variable latency
    initial begin
        forever begin
            @(negedge clk);
            if (smp_req_o) begin
                req_n++;
                repeat (req_n % 3) @(negedge clk);
                smp_val_i  = samp[smp_ch_o];
                smp_done_i = 1'b1;
                @(negedge clk);
                smp_done_i = 1'b0;
            end
        end
    end

    // FIFO write capture
    initial begin
        forever begin
            @(negedge clk);
            if (fifo_wr_o && cap_n < 16) begin
                cap[cap_n] = fifo_wdata_o;
                cap_n++;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    function automatic logic [31:0] nxt(input logic [31:0] s);
        logic [31:0] r;
        r = s ^ (s << 13);
        r = r ^ (r >> 17);
        r = r ^ (r << 5);
        return r;
    endfunction

    // one event; fc_t: negedge index after gate fall to pulse clr_i (fast mode), -1 none
    task automatic run_evt(input logic [7:0] en, input logic [7:0] lo, input logic [7:0] hi,
                           input logic [1:0] code, input int fc_t, input string tag);
        int d_exp, t, tb, tr, en_n, hit_n, exp_words;
        bit abort;
        logic [15:0] ew [9];
        d_exp = int'(code) * STEP + OFS;
        abort = (fc_t >= 1) && (fc_t <= d_exp + 1);
        chan_en_i = en; thr_lo_i = lo; thr_hi_i = hi; delay_code_i = code;
        en_n = 0; hit_n = 0;
        for (int c = 0; c < 8; c++) begin
            if (en[c]) begin
                en_n++;
                if (samp[c][11:4] > lo && samp[c][11:4] < hi) begin
                    ew[1 + hit_n] = {1'b0, 3'(c), samp[c]};
                    hit_n++;
                end
            end
        end
        ew[0] = {1'b1, 3'(hit_n - 1), 12'(exp_evt)};
        exp_words = (hit_n > 0) ? hit_n + 1 : 0;
        @(negedge clk);
        cap_n = 0; req_n = 0;
        gate_i = 1'b1;
        repeat (3) @(negedge clk);
        gate_i = 1'b0;
        t = 0; tb = -1; tr = -1;
        forever begin
            @(negedge clk);
            t++;
            if (busy_o && tb < 0) tb = t;
            if (smp_req_o && tr < 0) tr = t;
            clr_i = (t == fc_t);
            if (tb >= 0 && !busy_o) break;
            if (t > 3000) break;
        end
        clr_i = 1'b0;
        if (abort) begin
            chk(cap_n == 0, "R8 writes", cap_n, 0);
            chk(req_n == 0, "R8 requests", req_n, 0);
            chk(evt_cnt_o == 12'(exp_evt), "R8 counter", evt_cnt_o, exp_evt);
        end else begin
            chk(tb == 1, "R2 busy rise", tb, 1);
            chk(tr - tb == d_exp + 2, "R3 delay", tr - tb, d_exp + 2);
            chk(req_n == en_n + hit_n, {"R11 requests ", tag}, req_n, en_n + hit_n);
            chk(cap_n == exp_words, {"R7 word count ", tag}, cap_n, exp_words);
            for (int i = 0; i < exp_words && i < cap_n; i++) begin
                if (i == 0) chk(cap[0] == ew[0], {"R5 header ", tag}, cap[0], ew[0]);
                else        chk(cap[i] == ew[i], {"R6 data R4 window ", tag}, cap[i], ew[i]);
            end
            exp_evt = (exp_evt + 1) & 12'hFFF;
            chk(evt_cnt_o == 12'(exp_evt), {"R7 counter ", tag}, evt_cnt_o, exp_evt);
        end
    endtask

    initial begin
        for (int c = 0; c < 8; c++) samp[c] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk(busy_o == 1'b0, "R2 reset busy", busy_o, 0);
        chk(evt_cnt_o == '0, "R7 reset counter", evt_cnt_o, 0);
        chk(fifo_wr_o == 1'b0 && smp_req_o == 1'b0, "R11 reset idle", smp_req_o, 0);

        // R2: FIFO-blocking busy in both buffer modes
        for (int m = 0; m < 8; m++) begin
            buf_full_mode_i = m[2]; fifo_full_i = m[1]; fifo_half_i = m[0];
            #1;
            chk(busy_o == (m[2] ? m[1] : m[0]), "R2 fifo block", busy_o, m[2] ? m[1] : m[0]);
            @(negedge clk);
        end

        // R1: gate refused while FIFO blocks in half mode
        buf_full_mode_i = 1'b0; fifo_half_i = 1'b1; fifo_full_i = 1'b0;
        chan_en_i = 8'hFF; req_n = 0;
        gate_i = 1'b1; repeat (3) @(negedge clk); gate_i = 1'b0;
        fifo_half_i = 1'b0;
        repeat (40) @(negedge clk);
        chk(busy_o == 1'b0 && req_n == 0, "R1 blocked gate", req_n, 0);
        chk(evt_cnt_o == '0, "R1 blocked counter", evt_cnt_o, 0);

        // R1: gate refused with no channel enabled
        chan_en_i = 8'h00; req_n = 0;
        gate_i = 1'b1; repeat (3) @(negedge clk); gate_i = 1'b0;
        repeat (40) @(negedge clk);
        chk(busy_o == 1'b0 && req_n == 0, "R1 no enable", req_n, 0);
        chk(evt_cnt_o == '0, "R1 no enable counter", evt_cnt_o, 0);

        // R4: threshold edges
        samp[0] = 12'h400; samp[1] = 12'h41F; samp[2] = 12'h5FF; samp[3] = 12'h600;
        samp[4] = 12'h3FF; samp[5] = 12'h500; samp[6] = 12'hFFF; samp[7] = 12'h000;
        run_evt(8'hFF, 8'h40, 8'h60, 2'd0, -1, "edges");
        // R6: sparse enables, ascending order
        run_evt(8'hA5, 8'h00, 8'hFF, 2'd1, -1, "sparse");
        // R5: all eight in range, multiplicity field 7
        for (int c = 0; c < 8; c++) samp[c] = 12'h100 + 12'(c * 16);
        run_evt(8'hFF, 8'h00, 8'hFF, 2'd2, -1, "all");
        // R7: nothing in range
        run_evt(8'hFF, 8'h80, 8'h81, 2'd3, -1, "none");
        // R8: fast clear inside the wait
        run_evt(8'hFF, 8'h00, 8'hFF, 2'd1, 2, "abort");
        run_evt(8'h0F, 8'h00, 8'hFF, 2'd3, 3 * STEP + OFS + 1, "abort late");
        // R9: fast clear during the scan is ignored
        run_evt(8'hFF, 8'h00, 8'hFF, 2'd0, OFS + 3, "R9 scan clr");
        // R9: fast clear while idle is ignored
        @(negedge clk); clr_i = 1'b1; #1;
        chk(cfg_clear_o == 1'b0, "R9 idle strobe", cfg_clear_o, 0);
        @(negedge clk); clr_i = 1'b0;
        @(negedge clk);
        chk(evt_cnt_o == 12'(exp_evt) && !busy_o, "R9 idle counter", evt_cnt_o, exp_evt);

        // sweep over random enables, thresholds and samples
        for (int e = 0; e < 40; e++) begin
            logic [7:0] en, lo;
            seed = nxt(seed);
            en = seed[7:0] | 8'h01;
            lo = {1'b0, seed[14:8]};
            seed = nxt(seed);
            for (int c = 0; c < 8; c++) begin
                seed = nxt(seed);
                samp[c] = seed[11:0];
            end
            run_evt(en, lo, lo + 8'(16 + seed[20:15]), 2'(e), -1, "sweep");
        end

        // R10: reset-mode pulse during the wait
        fast_clr_mode_i = 1'b0;
        chan_en_i = 8'hFF; delay_code_i = 2'd3;
        @(negedge clk);
        gate_i = 1'b1; repeat (3) @(negedge clk); gate_i = 1'b0;
        repeat (3) @(negedge clk);
        chk(busy_o == 1'b1, "R10 busy before clear", busy_o, 1);
        clr_i = 1'b1; #1;
        chk(cfg_clear_o == 1'b1, "R10 strobe", cfg_clear_o, 1);
        @(negedge clk); clr_i = 1'b0;
        chk(evt_cnt_o == '0, "R10 counter", evt_cnt_o, 0);
        chk(busy_o == 1'b0, "R10 idle", busy_o, 0);
        exp_evt = 0;
        fast_clr_mode_i = 1'b1;
        repeat (30) @(negedge clk);
        for (int c = 0; c < 8; c++) samp[c] = 12'h200 + 12'(c);
        run_evt(8'h3C, 8'h10, 8'h30, 2'd0, -1, "after clear");

        finish_run();
    end
endmodule